// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Current-Steering DAC

This block sits between a multibit noise-shaping modulator and an array of unit current sources. Each time the clock enable pulses, it takes a level code and turns on that many unit elements. The enabled group starts at the element just after the last one used by the previous sample. Because the start position keeps moving round the array, every element is used equally often over time. Static mismatch between the elements is then pushed out of the signal band as first-order shaped noise, instead of showing up as harmonic distortion.

The block drives two registered vectors of equal width. Bit i of the positive vector switches element i to the positive output. The negative vector is the bitwise complement of the positive vector and steers the same element to the other output. A start pointer, counted modulo the element count, records where the next group begins. Level codes above the element count are treated as full scale.

Top module: `dwa_selector`

## Requirements
- R1: While the asynchronous active-low reset is asserted and after it is released, `sel_p` is all zeros, `sel_n` is all ones, and the start pointer is 0, so the first group after reset begins at element 0.
- R2: After a clock-enable cycle, `sel_p` holds exactly min(level, 32) ones.
- R3: At every clock edge outside reset, `sel_n` equals the bitwise inverse of `sel_p`.
- R4: For a level N with 0 < N < 32, the bits set in `sel_p` are at positions P, P+1, …, P+N-1. P is the pointer before the enable cycle, and bit i of `sel_p` controls element i.
- R5: After each clock-enable cycle, the pointer becomes (P + min(level, 32)) mod 32, so the next group starts at the element after the last one enabled.
- R6: A level of 0 produces an all-zero `sel_p` and leaves the pointer unchanged.
- R7: A level of 32 or more produces an all-ones `sel_p` and leaves the pointer unchanged. Any level above 32 is treated exactly as 32.
- R8: While `ce` is low, the value on `level` is ignored, and both `sel_p` and the pointer keep their values.
- R9: A group that runs past element 31 continues at element 0 (for example, P = 28 with N = 7 sets bits 28–31 and 0–2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Sample enable; accepts `level` and updates the outputs |
| level | input | 6 | Number of unit elements to switch on this sample |
| sel_p | output | 32 | Element enables for the positive output side |
| sel_n | output | 32 | Complement enables for the negative output side |

## Verification
The bench builds the block with its default values: 32 elements and a 6-bit level input. With these values the pointer wraps many times in a short run. The 6-bit input can also carry codes from 33 to 63, so the saturation path is exercised as well as the exact full-scale code. A directed sequence places the pointer near the top of the array to force wrapped groups. It also mixes zero and full-scale codes between ordinary ones and holds `ce` low while `level` changes. A long stretch of pseudo-random levels and enable gaps follows. A behavioural model of the pointer checks both vectors on every cycle.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  // Saturate a requested level to the number of available elements.
  function automatic int unsigned clamp_level(input int unsigned req,
                                              input int unsigned elems);
    return (req > elems) ? elems : req;
  endfunction

endpackage

// File: rtl/dwa_ptr.sv
module dwa_ptr #(
  parameter int unsigned ELEMS = 32,
  parameter int unsigned PTR_W = $clog2(ELEMS),
  parameter int unsigned CNT_W = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [CNT_W-1:0] step,
  output logic [PTR_W-1:0] ptr
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [SUM_W-1:0] sum;

  // Modulo add: step <= ELEMS and ptr < ELEMS, so at most one wrap.
  always_comb begin
    sum   = SUM_W'(ptr_q) + SUM_W'(step);
    ptr_d = ptr_q;
    if (ce) begin
      if (sum >= SUM_W'(ELEMS)) ptr_d = PTR_W'(sum - SUM_W'(ELEMS));
      else                      ptr_d = PTR_W'(sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R5: pointer advances by the clamped step modulo the element count
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (int'(ptr_q) == (int'($past(ptr_q)) + int'($past(step))) % int'(ELEMS)));

  // R8: pointer holds without an enable
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(ptr_q));

endmodule

// File: rtl/dwa_mask.sv
module dwa_mask #(
  parameter int unsigned ELEMS = 32,
  parameter int unsigned PTR_W = $clog2(ELEMS),
  parameter int unsigned CNT_W = $clog2(ELEMS + 1)
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [CNT_W-1:0] cnt,
  output logic [ELEMS-1:0] mask
);

  logic [ELEMS-1:0]   therm;
  logic [2*ELEMS-1:0] dbl;

  // Thermometer code anchored at element 0.
  for (genvar i = 0; i < ELEMS; i++) begin : g_therm
    assign therm[i] = (cnt > CNT_W'(i));
  end

  // Rotate left by the pointer; the upper half of the doubled shift
  // carries bits that cross the top element back to element 0.
  always_comb begin
    dbl  = {therm, therm} << ptr;
    mask = dbl[2*ELEMS-1:ELEMS];
  end

endmodule

// File: rtl/dwa_selector.sv
module dwa_selector #(
  parameter int unsigned ELEMS   = 32,
  parameter int unsigned LEVEL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic [LEVEL_W-1:0] level,
  output logic [ELEMS-1:0]   sel_p,
  output logic [ELEMS-1:0]   sel_n
);

  localparam int unsigned PTR_W = $clog2(ELEMS);
  localparam int unsigned CNT_W = $clog2(ELEMS + 1);

  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] ptr;
  logic [ELEMS-1:0] mask;
  logic [ELEMS-1:0] sel_p_q, sel_p_d;
  logic [ELEMS-1:0] sel_n_q, sel_n_d;

  // R7: saturate over-range codes to full scale
  always_comb begin
    cnt = CNT_W'(dwa_pkg::clamp_level(int'(level), ELEMS));
  end

  dwa_ptr #(.ELEMS(ELEMS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .ce   (ce),
    .step (cnt),
    .ptr  (ptr)
  );

  dwa_mask #(.ELEMS(ELEMS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_mask (
    .ptr (ptr),
    .cnt (cnt),
    .mask(mask)
  );

  always_comb begin
    sel_p_d = sel_p_q;
    sel_n_d = sel_n_q;
    if (ce) begin
      sel_p_d = mask;
      sel_n_d = ~mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_p_q <= '0;
      sel_n_q <= '1;
    end else begin
      sel_p_q <= sel_p_d;
      sel_n_q <= sel_n_d;
    end
  end

  assign sel_p = sel_p_q;
  assign sel_n = sel_n_q;

  // R3: the two sides are always complementary
  assert_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_q == ~sel_p_q);

  // R2: number of enabled elements matches the clamped level
  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> ($countones(sel_p_q) == int'($past(cnt))));

  // R6: zero level switches everything off
  assert_zero_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && level == '0) |=> (sel_p_q == '0));

  // R7: full-scale or over-range level switches everything on
  assert_full_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && int'(level) >= int'(ELEMS)) |=> (&sel_p_q));

  // R8: outputs hold while the enable is low
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(sel_p_q));

endmodule

// File: tb/dwa_selector_test.sv
module dwa_selector_test;

  logic        clk;
  logic        rst_n;
  logic        ce;
  logic [5:0]  level;
  logic [31:0] sel_p;
  logic [31:0] sel_n;

  int checks;
  int fails;
  int m_ptr;
  logic [31:0] m_exp;
  string m_tag;

  dwa_selector uut (
    .clk  (clk),
    .rst_n(rst_n),
    .ce   (ce),
    .level(level),
    .sel_p(sel_p),
    .sel_n(sel_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one sample on a falling edge; the model predicts the result.
  task automatic step(input logic en, input int lv);
    int n;
    int prev;
    @(negedge clk);
    ce    = en;
    level = 6'(lv);
    if (en) begin
      n     = (lv > 32) ? 32 : lv;
      prev  = m_ptr;
      m_exp = '0;
      for (int k = 0; k < n; k++) m_exp[(prev + k) % 32] = 1'b1;
      m_ptr = (prev + n) % 32;
      if (lv == 0)                     m_tag = "R6";
      else if (lv >= 32)               m_tag = "R7";
      else if (prev + n > 32)          m_tag = "R9";
      else if (prev != 0)              m_tag = "R5";
      else                             m_tag = "R4";
    end else begin
      m_tag = "R8";
    end
    @(negedge clk);
    chk(m_tag, sel_p, m_exp);
    chk("R3", sel_n, ~m_exp);
    checks++;
    if ($countones(sel_p) != $countones(m_exp)) begin
      fails++;
      $display("FAIL R2 actual=%0d expected=%0d", $countones(sel_p), $countones(m_exp));
    end
    ce = 1'b0;
  endtask

  initial begin
    checks = 0; fails = 0; m_ptr = 0; m_exp = '0; m_tag = "R1";
    rst_n = 1'b0; ce = 1'b0; level = '0;
    repeat (3) @(negedge clk);
    chk("R1", sel_p, 32'h0);
    chk("R1", sel_n, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", sel_p, 32'h0);
    // Directed: first group from element 0, then rotation and wrap
    step(1'b1, 5);
    step(1'b1, 0);
    step(1'b1, 32);
    step(1'b1, 40);
    step(1'b1, 23);          // pointer 28
    step(1'b1, 7);           // wraps: 28..31, 0..2
    step(1'b0, 17);          // ignored
    step(1'b0, 63);          // ignored
    step(1'b1, 1);
    step(1'b1, 31);
    step(1'b1, 63);
    step(1'b1, 33);
    // Pseudo-random levels with enable gaps
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, int'($urandom % 64));
    end
    // Reset mid-run returns pointer to element 0
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", sel_p, 32'h0);
    rst_n = 1'b1;
    m_ptr = 0; m_exp = '0;
    step(1'b1, 3);
    chk("R1", sel_p, 32'h0000_0007);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule